// File: doc/BRIEF.md
# Serial LED Status Shift Controller

This block collects per-port link state and traffic events from a four-port 10 Mb/s transceiver. It sends them as a serial stream to external shift registers that drive the status LEDs. One update frame starts at a fixed interval (50 ms at a 10 MHz system clock). During a frame the block drives a bit clock (1 MHz) and a data line, then raises a one-cycle strobe. Downstream logic can use that strobe to latch the register outputs once every bit is in place.

A strap input is taken as the block leaves reset and selects one of two frame layouts. The compact layout gives each port an activity bit and a status bit. The status bit encodes the port condition as a blink rate. The wide layout gives each port separate receive, transmit, duplex and coded-link bits. Short traffic pulses are held until the next frame so that they stay visible for a whole update period.

Top module: `ledStatusShifter`

## Requirements
- R1: While reset is asserted, ledClk is 0, ledData is 1 and updDone is 0.
- R2: Once the first frame has started, frames start every UPDATE_CYCLES clock cycles. updDone pulses once per frame, so consecutive pulses are exactly UPDATE_CYCLES cycles apart.
- R3: Each bit lasts BIT_DIV cycles. Rising edges of ledClk within a frame are BIT_DIV cycles apart. ledData does not change in a cycle where ledClk rises. ledClk is 0 in the cycle where updDone is 1.
- R4: In compact mode a frame holds 2*NUM_PORTS bits. Port 0 goes first. For each port, the activity bit is sent first, then the status bit.
- R5: In wide mode a frame holds 4*NUM_PORTS bits. Port 0 goes first. For each port the bits go in this order: receive, transmit, full duplex, coded link.
- R6: Every data bit is active low. A lit LED is sent as 0 and a dark one as 1.
- R7: A one-cycle pulse on txPulse or rxPulse for a port shows as active in the next frame. The pulse may arrive at any time from one frame's start up to and including the next frame's start cycle. Without a new pulse, the bit is inactive in the frame after that. In compact mode the activity bit is the OR of the transmit and receive pulses.
- R8: Compact status bit, where frame k is counted from 0 after reset. It is steadily on when linkUp=1 and polarityBad=0. It is on when (k/SLOW_UPDATES) is even, if linkUp=1 and polarityBad=1. It is on when (k/FAST_UPDATES) is even, if linkUp=0, whatever the value of polarityBad.
- R9: modeStrap is sampled at the first clock edge after reset is released: 0 selects wide mode and 1 selects compact mode. Later changes of modeStrap do not change the frame length.
- R10: updDone is high for exactly one cycle. This cycle is the one after the final high phase of ledClk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| modeStrap | input | 1 | Layout strap, 0 = wide, 1 = compact |
| txPulse | input | NUM_PORTS | Per-port transmit event pulses |
| rxPulse | input | NUM_PORTS | Per-port receive event pulses |
| linkUp | input | NUM_PORTS | Per-port link good |
| polarityBad | input | NUM_PORTS | Per-port reversed receive polarity |
| fullDuplex | input | NUM_PORTS | Per-port full-duplex state |
| codedLink | input | NUM_PORTS | Per-port coded-link state |
| ledClk | output | 1 | Serial bit clock to external registers |
| ledData | output | 1 | Serial active-low data, valid at ledClk rise |
| updDone | output | 1 | One-cycle end-of-frame strobe |

## Verification
The embedded properties assume three things. Event pulses are synchronous to clk. UPDATE_CYCLES is larger than one whole frame plus two cycles. The strap is held steady across the first edge after reset release. The stimulus changes status inputs and sends random pulses only in the idle gap between a done strobe and the next frame start. It holds the strap for several cycles after reset is released, and flips it only many frames later to show that the change has no effect.

// File: rtl/ledStatusPkg.sv
package ledStatusPkg;
  typedef struct packed {
    logic load;
    logic shift;
    logic finish;
  } ledStrobeT;
endpackage

// File: rtl/ledBlinker.sv
module ledBlinker #(
  parameter int TOGGLE_FRAMES = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  output logic phaseOn
);
  localparam int CW = (TOGGLE_FRAMES > 1) ? $clog2(TOGGLE_FRAMES) : 1;

  logic [CW-1:0] stepCnt;
  logic          phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepCnt <= '0;
      phase   <= 1'b0;
    end else if (step) begin
      if (stepCnt == CW'(TOGGLE_FRAMES - 1)) begin
        stepCnt <= '0;
        phase   <= ~phase;
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  assign phaseOn = ~phase;

  // R8: the phase flips only on a frame step
  a_r8_phase_moves_on_step: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(phase));
endmodule

// File: rtl/ledShiftCtrl.sv
module ledShiftCtrl
  import ledStatusPkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int BIT_DIV       = 10,
  parameter int UPDATE_CYCLES = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeStrap,
  output ledStrobeT strb,
  output logic      enhMode,
  output logic      ledClk,
  output logic      updDone
);
  localparam int MAX_BITS  = 4 * NUM_PORTS;
  localparam int NORM_BITS = 2 * NUM_PORTS;
  localparam int UPD_W     = $clog2(UPDATE_CYCLES);
  localparam int DIV_W     = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;
  localparam int BIT_W     = $clog2(MAX_BITS);
  localparam int HALF      = BIT_DIV / 2;

  typedef enum logic {ST_IDLE, ST_SHIFT} ctrlStateT;

  ctrlStateT        state;
  logic             armed;
  logic [UPD_W-1:0] updCnt;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             lastBit;
  logic             finQ;

  // strap capture at the first edge out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      enhMode <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (!armed) enhMode <= ~modeStrap;
    end
  end

  // update interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updCnt <= '0;
    end else if (armed) begin
      if (updCnt == UPD_W'(UPDATE_CYCLES - 1)) updCnt <= '0;
      else updCnt <= updCnt + 1'b1;
    end
  end

  assign lastBit = enhMode ? (bitCnt == BIT_W'(MAX_BITS - 1))
                           : (bitCnt == BIT_W'(NORM_BITS - 1));

  always_comb begin
    strb.load   = armed && (updCnt == '0) && (state == ST_IDLE);
    strb.shift  = (state == ST_SHIFT) && (divCnt == '0);
    strb.finish = (state == ST_SHIFT) && (divCnt == DIV_W'(BIT_DIV - 1)) && lastBit;
  end

  // bit sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (strb.load) begin
      state  <= ST_SHIFT;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (state == ST_SHIFT) begin
      if (divCnt == DIV_W'(BIT_DIV - 1)) begin
        divCnt <= '0;
        if (lastBit) state <= ST_IDLE;
        else bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledClk  <= 1'b0;
      finQ    <= 1'b0;
      updDone <= 1'b0;
    end else begin
      ledClk  <= (state == ST_SHIFT) && (divCnt >= DIV_W'(HALF));
      finQ    <= strb.finish;
      updDone <= finQ;
    end
  end

  // checker counters
  logic [BIT_W:0]   shiftSeen;
  logic [UPD_W:0]   gapCnt;
  logic             loadSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftSeen <= '0;
      gapCnt    <= '0;
      loadSeen  <= 1'b0;
    end else begin
      if (strb.load) shiftSeen <= '0;
      else if (strb.shift) shiftSeen <= shiftSeen + 1'b1;
      if (strb.load) begin
        gapCnt   <= '0;
        loadSeen <= 1'b1;
      end else begin
        gapCnt <= gapCnt + 1'b1;
      end
    end
  end

  a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.finish}));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    updDone |=> !updDone);

  a_r3_clk_low_at_done: assert property (@(posedge clk) disable iff (!rstN)
    updDone |-> !ledClk);

  a_r4_r5_frame_length: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (shiftSeen == (enhMode ? (BIT_W+1)'(MAX_BITS) : (BIT_W+1)'(NORM_BITS))));

  a_r2_frame_interval: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && loadSeen) |-> (gapCnt == (UPD_W+1)'(UPDATE_CYCLES - 1)));

  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(armed)) |-> $stable(enhMode));
endmodule

// File: rtl/ledShiftDatapath.sv
module ledShiftDatapath
  import ledStatusPkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int SLOW_UPDATES = 5,
  parameter int FAST_UPDATES = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ledStrobeT            strb,
  input  logic                 enhMode,
  input  logic [NUM_PORTS-1:0] txPulse,
  input  logic [NUM_PORTS-1:0] rxPulse,
  input  logic [NUM_PORTS-1:0] linkUp,
  input  logic [NUM_PORTS-1:0] polarityBad,
  input  logic [NUM_PORTS-1:0] fullDuplex,
  input  logic [NUM_PORTS-1:0] codedLink,
  output logic                 ledData
);
  localparam int MAX_BITS  = 4 * NUM_PORTS;
  localparam int NORM_BITS = 2 * NUM_PORTS;

  logic [NUM_PORTS-1:0] txHold, rxHold, txSeen, rxSeen, statusOn;
  logic [NORM_BITS-1:0] normFrame;
  logic [MAX_BITS-1:0]  enhFrame, nextFrame, shiftReg;
  logic                 slowOn, fastOn;

  // activity stretchers: events held until the next frame load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      rxHold <= '0;
    end else if (strb.load) begin
      txHold <= '0;
      rxHold <= '0;
    end else begin
      txHold <= txHold | txPulse;
      rxHold <= rxHold | rxPulse;
    end
  end

  assign txSeen = txHold | txPulse;
  assign rxSeen = rxHold | rxPulse;

  ledBlinker #(.TOGGLE_FRAMES(SLOW_UPDATES)) slowBlink_i (
    .clk(clk), .rstN(rstN), .step(strb.load), .phaseOn(slowOn));

  ledBlinker #(.TOGGLE_FRAMES(FAST_UPDATES)) fastBlink_i (
    .clk(clk), .rstN(rstN), .step(strb.load), .phaseOn(fastOn));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // link loss outranks bad polarity
    assign statusOn[p] = linkUp[p] ? (polarityBad[p] ? slowOn : 1'b1) : fastOn;
    assign normFrame[2*p]     = ~(txSeen[p] | rxSeen[p]);
    assign normFrame[2*p + 1] = ~statusOn[p];
    assign enhFrame[4*p]      = ~rxSeen[p];
    assign enhFrame[4*p + 1]  = ~txSeen[p];
    assign enhFrame[4*p + 2]  = ~fullDuplex[p];
    assign enhFrame[4*p + 3]  = ~codedLink[p];
  end

  assign nextFrame = enhMode ? enhFrame : {{(MAX_BITS - NORM_BITS){1'b1}}, normFrame};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
      ledData  <= 1'b1;
    end else if (strb.load) begin
      shiftReg <= nextFrame;
    end else if (strb.shift) begin
      ledData  <= shiftReg[0];
      shiftReg <= {1'b1, shiftReg[MAX_BITS-1:1]};
    end else if (strb.finish) begin
      shiftReg <= '1;
    end
  end

  // R7: a pulse outside a load cycle is remembered
  a_r7_pulse_held: assert property (@(posedge clk) disable iff (!rstN)
    ((|(txPulse | rxPulse)) && !strb.load) |=> (|(txHold | rxHold)));
endmodule

// File: rtl/ledStatusShifter.sv
module ledStatusShifter
  import ledStatusPkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int BIT_DIV       = 10,
  parameter int UPDATE_CYCLES = 500000,
  parameter int SLOW_UPDATES  = 5,
  parameter int FAST_UPDATES  = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeStrap,
  input  logic [NUM_PORTS-1:0] txPulse,
  input  logic [NUM_PORTS-1:0] rxPulse,
  input  logic [NUM_PORTS-1:0] linkUp,
  input  logic [NUM_PORTS-1:0] polarityBad,
  input  logic [NUM_PORTS-1:0] fullDuplex,
  input  logic [NUM_PORTS-1:0] codedLink,
  output logic                 ledClk,
  output logic                 ledData,
  output logic                 updDone
);
  ledStrobeT strb;
  logic      enhMode;

  ledShiftCtrl #(
    .NUM_PORTS(NUM_PORTS), .BIT_DIV(BIT_DIV), .UPDATE_CYCLES(UPDATE_CYCLES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .strb(strb),
    .enhMode(enhMode), .ledClk(ledClk), .updDone(updDone));

  ledShiftDatapath #(
    .NUM_PORTS(NUM_PORTS), .SLOW_UPDATES(SLOW_UPDATES), .FAST_UPDATES(FAST_UPDATES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .enhMode(enhMode),
    .txPulse(txPulse), .rxPulse(rxPulse), .linkUp(linkUp),
    .polarityBad(polarityBad), .fullDuplex(fullDuplex), .codedLink(codedLink),
    .ledData(ledData));

  // R3: data is settled when the external register clocks it
  a_r3_data_stable_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ledClk) |-> $stable(ledData));
endmodule

// File: tb/ledStatusShifter_tb_top.sv
`timescale 1ns/1ps
module ledStatusShifter_tb_top;
  localparam int CLK_PERIOD = 100;
  localparam int NP         = 4;
  localparam int BIT_DIV    = 4;
  localparam int UPD        = 300;
  localparam int SLOW       = 5;
  localparam int FAST       = 1;
  localparam int NFRAMES    = 24;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeStrap = 1'b1;
  logic [NP-1:0] txPulse = '0, rxPulse = '0, linkUp = '0, polarityBad = '0;
  logic [NP-1:0] fullDuplex = '0, codedLink = '0;
  logic ledClk, ledData, updDone;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ledStatusShifter #(
    .NUM_PORTS(NP), .BIT_DIV(BIT_DIV), .UPDATE_CYCLES(UPD),
    .SLOW_UPDATES(SLOW), .FAST_UPDATES(FAST)
  ) dut_i (
    .clk(clk), .rstN(rstN), .modeStrap(modeStrap), .txPulse(txPulse),
    .rxPulse(rxPulse), .linkUp(linkUp), .polarityBad(polarityBad),
    .fullDuplex(fullDuplex), .codedLink(codedLink), .ledClk(ledClk),
    .ledData(ledData), .updDone(updDone));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expFrame(input bit enh, input logic [NP-1:0] tx,
      input logic [NP-1:0] rx, input logic [NP-1:0] lk, input logic [NP-1:0] pb,
      input logic [NP-1:0] fd, input logic [NP-1:0] cd, input int k);
    logic [15:0] f;
    bit slowOn, fastOn;
    f = '1;
    slowOn = ((k / SLOW) % 2) == 0;
    fastOn = ((k / FAST) % 2) == 0;
    for (int p = 0; p < NP; p++) begin
      bit st;
      st = lk[p] ? (pb[p] ? slowOn : 1'b1) : fastOn;
      if (enh) begin
        f[4*p]     = ~rx[p];
        f[4*p + 1] = ~tx[p];
        f[4*p + 2] = ~fd[p];
        f[4*p + 3] = ~cd[p];
      end else begin
        f[2*p]     = ~(tx[p] | rx[p]);
        f[2*p + 1] = ~st;
      end
    end
    return f;
  endfunction

  task automatic runFrame(output logic [15:0] capOut, output int nBits,
      output int periodErrs, output int doneCyc, output bit clkAtDone);
    logic [15:0] c;
    int n, pe, lr;
    logic prev;
    c = '1; n = 0; pe = 0; lr = -1; prev = 1'b0;
    forever begin
      @(negedge clk);
      if (ledClk && !prev) begin
        if (n < 16) c[n] = ledData;
        if (lr >= 0 && (cyc - lr) != BIT_DIV) pe++;
        lr = cyc;
        n++;
      end
      prev = ledClk;
      if (updDone) break;
    end
    capOut = c; nBits = n; periodErrs = pe; doneCyc = cyc; clkAtDone = ledClk;
  endtask

  task automatic checkReset();
    check(ledClk == 1'b0, "R1 ledClk in reset", ledClk, 0);
    check(ledData == 1'b1, "R1 ledData in reset", ledData, 1);
    check(updDone == 1'b0, "R1 updDone in reset", updDone, 0);
  endtask

  task automatic runPhase(input bit enh);
    logic [NP-1:0] tx, rx;
    logic [15:0] cap, ex;
    int nb, pe, dc, prevDone, expLen;
    bit clkLow;
    int txAt[NP];
    int rxAt[NP];
    tx = '0; rx = '0; prevDone = -1;
    expLen = enh ? 4*NP : 2*NP;
    for (int k = 0; k < NFRAMES; k++) begin
      if (k > 0) begin
        @(negedge clk);
        check(updDone == 1'b0, "R10 done lasts one cycle", updDone, 0);
        linkUp = NP'($urandom); polarityBad = NP'($urandom);
        fullDuplex = NP'($urandom); codedLink = NP'($urandom);
        if (k == 3) begin linkUp = '0; polarityBad = '1; end
        if (k == 6) begin linkUp = '1; polarityBad = '1; end
        if (k == 8) modeStrap = ~modeStrap;
        for (int p = 0; p < NP; p++) begin
          txAt[p] = ($urandom % 3 == 0) ? -1 : int'($urandom % 40);
          rxAt[p] = ($urandom % 3 == 0) ? -1 : int'($urandom % 40);
          if (k == 4) begin txAt[p] = -1; rxAt[p] = -1; end
          if (k == 5) begin txAt[p] = p; rxAt[p] = 39 - p; end
          tx[p] = (txAt[p] >= 0);
          rx[p] = (rxAt[p] >= 0);
        end
        for (int c = 0; c < 50; c++) begin
          for (int p = 0; p < NP; p++) begin
            txPulse[p] = (txAt[p] == c);
            rxPulse[p] = (rxAt[p] == c);
          end
          @(negedge clk);
        end
        txPulse = '0; rxPulse = '0;
      end
      runFrame(cap, nb, pe, dc, clkLow);
      ex = expFrame(enh, tx, rx, linkUp, polarityBad, fullDuplex, codedLink, k);
      if (k >= 8) check(nb == expLen, "R9 strap change ignored, frame length", nb, expLen);
      else check(nb == expLen, enh ? "R5 frame length" : "R4 frame length", nb, expLen);
      if (k == 0) check(cap == ex, "R6 active-low idle frame", cap, ex);
      else if (k == 3 || k == 6) check(cap == ex, "R8 blink priority frame", cap, ex);
      else if (k == 4 || k == 5) check(cap == ex, "R7 stretch on/off frame", cap, ex);
      else check(cap == ex, enh ? "R5 frame content" : "R4 frame content", cap, ex);
      check(pe == 0, "R3 bit period", pe, 0);
      check(clkLow == 1'b0, "R10 clock low at done", clkLow, 0);
      if (prevDone >= 0) check((dc - prevDone) == UPD, "R2 update interval", dc - prevDone, UPD);
      prevDone = dc;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1ed5));
    repeat (5) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runPhase(1'b0);
    @(negedge clk);
    rstN = 1'b0;
    modeStrap = 1'b0;
    linkUp = '0; polarityBad = '0; fullDuplex = '0; codedLink = '0;
    repeat (5) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    runPhase(1'b1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule